// File: doc/BRIEF.md
# Fixed-Width Truncated Radix-4 Booth Multiplier

This block multiplies two N-bit two's-complement operands and returns only the upper N bits of the 2N-bit product. The datapath is purely combinational. The multiplier operand is recoded into N/2 radix-4 signed digits. Each digit selects a partial-product row of zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The low product columns are never built, which saves most of the array area.

Only the top N+W columns of the partial-product matrix are summed. W is a parameter from 0 to N-1 that trades gates for accuracy. The carry that the removed columns would have sent upward is estimated from the digit control signals alone. The estimate is added at the lowest kept column. The W lowest kept columns are then dropped to give the N-bit result. The block suits accumulation-heavy datapaths, where a fixed output width and a small error that is centred on zero matter more than exact rounding.

Top module: `fwbm_top`

## Requirements
- R1: With b[-1] taken as 0, digit j (j = 0 .. N/2-1) has the value -2*b[2j+1] + b[2j] + b[2j-1], which is one of -2, -1, 0, +1, +2.
- R2: For each digit, the encoder asserts one-times when b[2j] differs from b[2j-1]. It asserts two-times for the bit groups 011 and 100, written {b[2j+1], b[2j], b[2j-1]}. It asserts negate when b[2j+1] is 1 and the group is not 111. One-times and two-times are never both set.
- R3: Row j is the digit times the multiplicand, sign-extended and placed at weight 4^j. For a negative digit, the row holds the bitwise inverse of the magnitude term and a separate negate bit. Only the columns at and above L = N-W are summed.
- R4: A row's negate bit is added at weight 2^(2j) when 2j >= L. Otherwise it is not added and is counted as one unit of compensation input.
- R5: The compensation value is floor((z + q + 1) / 2) and is added at weight 2^L. Here z is the number of nonzero digits and q is the number of negate bits counted as input under R4.
- R6: The output equals bits [2N-1:N] of the kept-column sum taken modulo 2^(2N). In other words, the W lowest kept columns are discarded.
- R7: When b is zero, the output is zero for any a.
- R8: Let E = floor(a*b / 2^N), computed from the signed product. The signed output never differs from E by more than ceil(3N / 2^(W+2)) + 1.
- R9: The most negative operand multiplied by itself gives 2^(N-2), with no wrap of the sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement, Booth recoded |
| p_o | output | N | Upper N bits of the compensated truncated product |

## Verification
The bench targets the digit patterns where truncation behaves differently. A negative low digit with a zero multiplicand leaves a column of all ones in the kept area, and only the compensation cancels it. A design that mishandled the dropped negate bits would return all ones or be off by one there. Mixed-sign products near full scale and the most-negative square would expose a wrong sign extension or a lost top carry as a large error. A wrong rounding of the compensation count, or a wrong split of negate bits between the kept and removed columns, would appear as single-LSB mismatches against the bit-exact model over random operands.

// File: rtl/fwbm_pkg.sv
package fwbm_pkg;

  typedef struct packed {
    logic one_x;
    logic two_x;
    logic neg;
  } booth_sel_t;

endpackage

// File: rtl/fwbm_booth_enc.sv
module fwbm_booth_enc
  import fwbm_pkg::*;
(
  input  logic [2:0]  grp_i,  // {b[2j+1], b[2j], b[2j-1]}
  output booth_sel_t  sel_o
);

  always_comb begin
    sel_o.one_x = grp_i[1] ^ grp_i[0];
    sel_o.two_x = (grp_i == 3'b011) | (grp_i == 3'b100);
    // no negate for the zero digit 111, so its row stays all zero
    sel_o.neg   = grp_i[2] & ~(grp_i[1] & grp_i[0]);
  end

endmodule

// File: rtl/fwbm_pp_row.sv
module fwbm_pp_row
  import fwbm_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 4,
  parameter int J = 0
) (
  input  logic [N-1:0]   a_i,
  input  booth_sel_t     sel_i,
  output logic [N+W-1:0] row_o,
  output logic [N+W-1:0] neg_o,
  output logic           neg_lo_o
);

  localparam int L  = N - W;
  localparam int KW = N + W;
  localparam int SH = 2 * J;

  logic [N:0]     mag;
  logic [N:0]     inv;
  logic [2*N-1:0] full;

  always_comb begin
    if (sel_i.one_x)      mag = {a_i[N-1], a_i};
    else if (sel_i.two_x) mag = {a_i, 1'b0};
    else                  mag = '0;
    inv  = sel_i.neg ? ~mag : mag;
    full = {{(N-1){inv[N]}}, inv} << SH;
    row_o = full[2*N-1:L];
  end

  generate
    if (SH >= L) begin : g_neg_kept
      assign neg_o    = {{(KW-1){1'b0}}, sel_i.neg} << (SH - L);
      assign neg_lo_o = 1'b0;
    end else begin : g_neg_dropped
      assign neg_o    = '0;
      assign neg_lo_o = sel_i.neg;
    end
  endgenerate

endmodule

// File: rtl/fwbm_comp.sv
module fwbm_comp
  import fwbm_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  booth_sel_t [N/2-1:0] sel_i,
  input  logic [N/2-1:0]       neg_lo_i,
  output logic [CW-1:0]        comp_o
);

  localparam int ND = N / 2;

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int j = 0; j < ND; j++) begin
      cnt = cnt + CW'(sel_i[j].one_x | sel_i[j].two_x);
      cnt = cnt + CW'(neg_lo_i[j]);
    end
    comp_o = (cnt + CW'(1)) >> 1;  // halve, round half up
  end

endmodule

// File: rtl/fwbm_sum.sv
module fwbm_sum #(
  parameter int N  = 16,
  parameter int W  = 4,
  parameter int CW = 5
) (
  input  logic [N/2-1:0][N+W-1:0] row_i,
  input  logic [N/2-1:0][N+W-1:0] neg_i,
  input  logic [CW-1:0]           comp_i,
  output logic [N-1:0]            p_o
);

  localparam int ND = N / 2;
  localparam int KW = N + W;

  logic [KW-1:0] acc;

  always_comb begin
    acc = {{(KW-CW){1'b0}}, comp_i};
    for (int j = 0; j < ND; j++) begin
      acc = acc + row_i[j] + neg_i[j];
    end
    p_o = acc[KW-1:W];
  end

endmodule

// File: rtl/fwbm_top.sv
module fwbm_top
  import fwbm_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] p_o
);

  localparam int ND = N / 2;
  localparam int KW = N + W;
  localparam int CW = $clog2(N + 2);

  logic [N:0]               b_ext;
  booth_sel_t [ND-1:0]      sel;
  logic [ND-1:0][KW-1:0]    rows;
  logic [ND-1:0][KW-1:0]    negs;
  logic [ND-1:0]            neg_lo;
  logic [CW-1:0]            comp;

  assign b_ext = {b_i, 1'b0};

  generate
    for (genvar j = 0; j < ND; j++) begin : g_digit
      fwbm_booth_enc u_enc (
        .grp_i (b_ext[2*j+2:2*j]),
        .sel_o (sel[j])
      );
      fwbm_pp_row #(.N(N), .W(W), .J(j)) u_row (
        .a_i      (a_i),
        .sel_i    (sel[j]),
        .row_o    (rows[j]),
        .neg_o    (negs[j]),
        .neg_lo_o (neg_lo[j])
      );
    end
  endgenerate

  fwbm_comp #(.N(N), .CW(CW)) u_comp (
    .sel_i    (sel),
    .neg_lo_i (neg_lo),
    .comp_o   (comp)
  );

  fwbm_sum #(.N(N), .W(W), .CW(CW)) u_sum (
    .row_i  (rows),
    .neg_i  (negs),
    .comp_i (comp),
    .p_o    (p_o)
  );

endmodule

// File: rtl/fwbm_checker.sv
module fwbm_checker
  import fwbm_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 4,
  parameter int CW = 5
) (
  input logic [N-1:0]          a_i,
  input logic [N-1:0]          b_i,
  input logic [N-1:0]          p_o,
  input booth_sel_t [N/2-1:0]  sel_i,
  input logic [CW-1:0]         comp_i
);

  localparam int ND    = N / 2;
  localparam int DEN   = 1 << (W + 2);
  localparam int BOUND = (3 * N + DEN - 1) / DEN + 1;

  logic [N:0] b_ext;
  assign b_ext = {b_i, 1'b0};

  generate
    for (genvar j = 0; j < ND; j++) begin : g_dig
      int dv_bits;
      int dv_sel;
      always_comb begin
        dv_bits = -2 * int'(b_ext[2*j+2]) + int'(b_ext[2*j+1]) + int'(b_ext[2*j]);
        dv_sel  = sel_i[j].one_x ? 1 : (sel_i[j].two_x ? 2 : 0);
        if (sel_i[j].neg) dv_sel = -dv_sel;
        p_sel_onehot_r2: assert ($onehot0({sel_i[j].one_x, sel_i[j].two_x}))
          else $error("one-times and two-times both set");
        p_digit_value_r1: assert (dv_sel == dv_bits)
          else $error("digit %0d decodes to %0d, expected %0d", j, dv_sel, dv_bits);
      end
    end
  endgenerate

  logic signed [2*N-1:0] exact;
  logic signed [N+1:0]   diff;

  always_comb begin
    exact = $signed(a_i) * $signed(b_i);
    diff  = (N+2)'($signed(p_o)) - (N+2)'($signed(exact[2*N-1:N]));
    p_err_bound_r8: assert (diff <= (N+2)'(BOUND) && diff >= -(N+2)'(BOUND))
      else $error("error %0d beyond bound %0d", diff, BOUND);
    p_zero_mult_r7: assert (b_i != '0 || (p_o == '0 && comp_i == '0))
      else $error("nonzero output for zero multiplier");
    p_min_square_r9: assert (!(a_i == {1'b1, {(N-1){1'b0}}} && b_i == {1'b1, {(N-1){1'b0}}})
                             || p_o == (N'(1) << (N - 2)))
      else $error("most-negative square wrong");
  end

endmodule

bind fwbm_top fwbm_checker #(.N(N), .W(W), .CW(CW)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .p_o    (p_o),
  .sel_i  (sel),
  .comp_i (comp)
);

// File: tb/tb_fwbm_top.sv
module tb_fwbm_top;

  localparam int N   = 16;
  localparam int W   = 4;
  localparam int L   = N - W;
  localparam int DEN = 1 << (W + 2);
  localparam int BOUND = (3 * N + DEN - 1) / DEN + 1;

  typedef struct packed {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] exp;
    logic         has_exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 16'h0000, 1'b1},
    '{16'h1234, 16'h0000, 16'h0000, 1'b1},
    '{16'h0000, 16'h7FFF, 16'h0000, 1'b1},
    '{16'h0001, 16'h0001, 16'h0000, 1'b1},
    '{16'h7FFF, 16'h0001, 16'h0000, 1'b1},
    '{16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    '{16'h4000, 16'h4000, 16'h1000, 1'b1},
    '{16'h8000, 16'h8000, 16'h4000, 1'b1},
    '{16'h8000, 16'h7FFF, 16'hC000, 1'b1},
    '{16'h7FFF, 16'h7FFF, 16'h0000, 1'b0},
    '{16'hA5A5, 16'h5A5A, 16'h0000, 1'b0},
    '{16'h0003, 16'hFFFD, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic [N-1:0] p_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fwbm_top #(.N(N), .W(W)) dut (.a_i(a_i), .b_i(b_i), .p_o(p_o));

  // bit-exact model built from R1-style digits with the R3..R6 rules
  function automatic logic [N-1:0] model(logic [N-1:0] a, logic [N-1:0] b);
    longint sa    = longint'($signed(a));
    longint m2n   = (longint'(1) << (2*N)) - 1;
    longint keepm = m2n & ~((longint'(1) << L) - 1);
    longint sum   = 0;
    longint nz    = 0;
    longint nlo   = 0;
    for (int j = 0; j < N/2; j++) begin
      longint bm1 = (j == 0) ? 0 : longint'(b[2*j-1]);
      longint d   = -2 * longint'(b[2*j+1]) + longint'(b[2*j]) + bm1;
      if (d != 0) nz++;
      if (d < 0) begin
        longint mag = (-d) * sa;
        sum += ((~mag) << (2*j)) & keepm;
        if (2*j >= L) sum += longint'(1) << (2*j);
        else nlo++;
      end else begin
        sum += ((d * sa) << (2*j)) & keepm;
      end
    end
    sum += ((nz + nlo + 1) >> 1) << L;
    sum &= m2n;
    return N'(sum >> N);
  endfunction

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a_i, b_i, got, exp);
    end
  endtask

  task automatic check_bound(string req);
    longint ex = longint'($signed(a_i)) * longint'($signed(b_i));
    longint eh = ex >>> N;
    longint df = longint'($signed(p_o)) - eh;
    checks++;
    if (df > BOUND || df < -BOUND) begin
      errors++;
      $display("FAIL %s a=%h b=%h got err=%0d exp |err|<=%0d", req, a_i, b_i, df, BOUND);
    end
  endtask

  task automatic apply(logic [N-1:0] a, logic [N-1:0] b);
    @(posedge clk);
    a_i = a;
    b_i = b;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 idle", p_o, '0);

    // table walk: hand values first, model and bound for every entry
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b);
      if (VECS[i].has_exp) check("R6 table", p_o, VECS[i].exp);
      check("R5 table model", p_o, model(VECS[i].a, VECS[i].b));
      check_bound("R8 table");
    end

    // R7: zero multiplier with varied multiplicands
    foreach (VECS[i]) begin
      apply(VECS[i].a ^ 16'h3C3C, '0);
      check("R7 zero b", p_o, '0);
    end

    // R9: most-negative square
    apply(16'h8000, 16'h8000);
    check("R9 min square", p_o, 16'h4000);

    // R1/R2: one multiplier pattern per digit value in every digit slot
    for (int j = 0; j < N/2; j++) begin
      for (int g = 0; g < 8; g++) begin
        logic [N:0] be = '0;
        be[2*j +: 3] = 3'(g);
        apply(16'h5A3B, be[N:1]);
        check("R1 R2 digit", p_o, model(16'h5A3B, be[N:1]));
      end
    end

    // R4: negative digits straddling the kept boundary L
    for (int j = 0; j < N/2; j++) begin
      logic [N-1:0] bb = N'(3) << (2*j);
      apply(16'h0000, bb);
      check("R4 neg split", p_o, model(16'h0000, bb));
      apply(16'h7FFF, bb);
      check("R4 neg split", p_o, model(16'h7FFF, bb));
      apply(16'h8000, bb);
      check("R3 sign ext", p_o, model(16'h8000, bb));
    end

    // random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ra = N'($urandom);
      logic [N-1:0] rb = N'($urandom);
      apply(ra, rb);
      check("R5 R6 random", p_o, model(ra, rb));
      check_bound("R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule